// File: doc/BRIEF.md
# ATA DMA Receive Sequencer

This block is the host-side engine that pulls data from an ATA drive into a local receive FIFO during a device-to-host DMA transfer. Software arms it with a pending bit, a direction bit and a mode bit. The block then waits for the drive's DMA request and answers with DMA acknowledge. After that it captures one 16-bit halfword from the drive data bus on each tick of a programmable strobe timer and writes it into the FIFO.

The transfer stalls when any one of these holds: the FIFO is full, the drive drops its request, or software clears the pending bit. A host access to drive registers also stalls it. The engine holds the acknowledge through an ordinary stall. For a register access it releases the bus and grants the access. When every stall cause has cleared, the transfer continues by itself and no word is lost. The drive ends the transfer by raising its interrupt line. The engine then drops the acknowledge and reports idle.

The mode bit is sampled when the engine is armed. Ultra mode moves one word every `strobeGap+1` clocks. Multiword mode moves one word every `2*(strobeGap+1)` clocks, because each word needs both an asserted and a negated strobe phase.

Top module: `ata_rx_dma_engine`

## Requirements
- R1: When `dmaPending`=1, `dirToDevice`=0 and `driveReq`=1, the engine leaves idle and asserts `driveAck` within 4 clocks.
- R2: While `dirToDevice`=1 or `dmaPending`=0, an idle engine stays idle with `driveAck`=0 and performs no FIFO write.
- R3: `ultraSel` is sampled when the engine leaves idle and shown on `ultraActive`. In a steady transfer, consecutive writes are `strobeGap+1` clocks apart when `ultraActive`=1 and `2*(strobeGap+1)` clocks apart when `ultraActive`=0.
- R4: Each FIFO write (`fifoWrEn`=1 for one clock) carries the value on `driveData` in that clock. No strobe tick is dropped or duplicated.
- R5: No write occurs in a clock where `fifoFull`=1. While the FIFO is full, `driveAck` stays asserted.
- R6: No write occurs in a clock where `driveReq`=0.
- R7: No write occurs in a clock where `dmaPending`=0.
- R8: After every stall cause clears, writes resume without software action.
- R9: While `pioReq`=1 during a transfer, `pioGrant`=1 follows within 3 clocks, `driveAck`=0 and no write occurs. After release, `driveAck` returns and writes resume.
- R10: `driveIntr`=1 while `driveAck`=1 deasserts `driveAck` and sets `engineIdle` on the next clock.
- R11: After reset, `engineIdle`=1, `driveAck`=0, `fifoWrEn`=0 and `pioGrant`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaPending | input | 1 | Software arm / run bit |
| dirToDevice | input | 1 | 1 = host-to-device (not served), 0 = device-to-host |
| ultraSel | input | 1 | 1 = ultra DMA, 0 = multiword DMA |
| strobeGap | input | GAP_W | Strobe timer reload value |
| pioReq | input | 1 | Host request to access drive registers |
| fifoFull | input | 1 | Receive FIFO full flag |
| driveReq | input | 1 | Drive DMA request |
| driveIntr | input | 1 | Drive interrupt (end of transfer) |
| driveData | input | 16 | Drive data bus |
| driveAck | output | 1 | DMA acknowledge to drive |
| pioGrant | output | 1 | Host register access permitted |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 16 | FIFO write data |
| engineIdle | output | 1 | Engine fully stopped |
| ultraActive | output | 1 | Mode latched for current transfer |

## Verification
On every cycle, the assertions check the safety rules. No write is allowed while the FIFO is full, while the request is low, while pending is clear or while acknowledge is low. The acknowledge and the register-access grant are mutually exclusive. The interrupt drops the acknowledge on the next clock, and an idle engine cannot start in the wrong direction. Only the bench scenarios can show the liveness side: automatic resumption after each stall cause, the exact word spacing in both modes, and an unbroken data sequence under random stalls.

// File: rtl/ata_rx_pkg.sv
package ata_rx_pkg;
  typedef enum logic [2:0] {
    IDLE, WAIT_REQ, ACK, XFER, PAUSE, PIO_ACCESS
  } rxState_t;

  typedef struct packed {
    logic latchMode;
    logic runCnt;
    logic clrCnt;
  } rxStrobes_t;
endpackage

// File: rtl/ata_rx_ctrl.sv
module ata_rx_ctrl
  import ata_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaPending,
  input  logic       dirToDevice,
  input  logic       pioReq,
  input  logic       fifoFull,
  input  logic       driveReq,
  input  logic       driveIntr,
  input  logic       tick,
  output rxStrobes_t strb,
  output logic       capture,
  output logic       driveAck,
  output logic       pioGrant,
  output logic       engineIdle
);
  rxState_t st, nxt;
  logic stallCause;

  assign stallCause = fifoFull || !driveReq || !dmaPending;

  always_comb begin
    nxt = st;
    unique case (st)
      IDLE:
        if (dmaPending && !dirToDevice) nxt = WAIT_REQ;
      WAIT_REQ:
        if (driveIntr || !dmaPending || dirToDevice) nxt = IDLE;
        else if (pioReq)                            nxt = PIO_ACCESS;
        else if (driveReq)                          nxt = ACK;
      ACK:
        if (driveIntr)   nxt = IDLE;
        else if (pioReq) nxt = PIO_ACCESS;
        else             nxt = XFER;
      XFER, PAUSE:
        if (driveIntr)       nxt = IDLE;
        else if (pioReq)     nxt = PIO_ACCESS;
        else if (stallCause) nxt = PAUSE;
        else                 nxt = XFER;
      PIO_ACCESS:
        if (driveIntr)    nxt = IDLE;
        else if (!pioReq) nxt = WAIT_REQ;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= IDLE;
    else       st <= nxt;
  end

  always_comb begin
    strb.latchMode = (st == IDLE) && (nxt == WAIT_REQ);
    strb.runCnt    = (st == XFER) && (nxt == XFER);
    strb.clrCnt    = (st == IDLE) || (st == WAIT_REQ) || (st == ACK) || (st == PIO_ACCESS);
  end

  assign capture    = strb.runCnt && tick;
  assign driveAck   = (st == ACK) || (st == XFER) || (st == PAUSE);
  assign pioGrant   = (st == PIO_ACCESS) || (st == IDLE);
  assign engineIdle = (st == IDLE);
endmodule

// File: rtl/ata_rx_datapath.sv
module ata_rx_datapath
  import ata_rx_pkg::*;
#(
  parameter int GAP_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strb,
  input  logic              ultraSel,
  input  logic [GAP_W-1:0]  strobeGap,
  input  logic [DATA_W-1:0] driveData,
  output logic              tick,
  output logic              ultraActive,
  output logic [DATA_W-1:0] fifoWrData
);
  localparam int CNT_W = GAP_W + 1;

  logic [CNT_W-1:0] cnt, limit;
  logic modeReg;

  // multiword spends two strobe phases per word
  assign limit = modeReg ? {1'b0, strobeGap} : {strobeGap, 1'b1};
  assign tick  = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      modeReg <= 1'b0;
    end else begin
      if (strb.latchMode) modeReg <= ultraSel;
      if (strb.clrCnt)      cnt <= '0;
      else if (strb.runCnt) cnt <= tick ? '0 : cnt + 1'b1;
    end
  end

  assign ultraActive = modeReg;
  assign fifoWrData  = driveData;
endmodule

// File: rtl/ata_rx_dma_engine.sv
module ata_rx_dma_engine
  import ata_rx_pkg::*;
#(
  parameter int GAP_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaPending,
  input  logic              dirToDevice,
  input  logic              ultraSel,
  input  logic [GAP_W-1:0]  strobeGap,
  input  logic              pioReq,
  input  logic              fifoFull,
  input  logic              driveReq,
  input  logic              driveIntr,
  input  logic [DATA_W-1:0] driveData,
  output logic              driveAck,
  output logic              pioGrant,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              engineIdle,
  output logic              ultraActive
);
  rxStrobes_t strb;
  logic tick;

  ata_rx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .dmaPending(dmaPending), .dirToDevice(dirToDevice),
    .pioReq(pioReq), .fifoFull(fifoFull), .driveReq(driveReq), .driveIntr(driveIntr),
    .tick(tick), .strb(strb), .capture(fifoWrEn), .driveAck(driveAck),
    .pioGrant(pioGrant), .engineIdle(engineIdle)
  );

  ata_rx_datapath #(.GAP_W(GAP_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .ultraSel(ultraSel), .strobeGap(strobeGap),
    .driveData(driveData), .tick(tick), .ultraActive(ultraActive), .fifoWrData(fifoWrData)
  );
endmodule

// File: rtl/ata_rx_dma_chk.sv
module ata_rx_dma_chk (
  input logic clk,
  input logic rstN,
  input logic dmaPending,
  input logic dirToDevice,
  input logic fifoFull,
  input logic driveReq,
  input logic driveIntr,
  input logic driveAck,
  input logic pioGrant,
  input logic fifoWrEn,
  input logic engineIdle
);
  // R5
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> !fifoFull);
  // R6
  no_write_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> driveReq);
  // R7
  no_write_unarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> dmaPending);
  // R4
  write_under_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> driveAck);
  // R9
  grant_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    pioGrant |-> !driveAck);
  // R10
  intr_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (driveIntr && driveAck) |=> (!driveAck && engineIdle));
  // R2
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engineIdle && (dirToDevice || !dmaPending)) |=> engineIdle);
endmodule

bind ata_rx_dma_engine ata_rx_dma_chk uChk (
  .clk(clk), .rstN(rstN), .dmaPending(dmaPending), .dirToDevice(dirToDevice),
  .fifoFull(fifoFull), .driveReq(driveReq), .driveIntr(driveIntr),
  .driveAck(driveAck), .pioGrant(pioGrant), .fifoWrEn(fifoWrEn), .engineIdle(engineIdle)
);

// File: tb/ata_rx_dma_engine_test.sv
`timescale 1ns/1ps
module ata_rx_dma_engine_test;
  localparam int GAP_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaPending = 1'b0, dirToDevice = 1'b0, ultraSel = 1'b0;
  logic [GAP_W-1:0] strobeGap = '0;
  logic pioReq = 1'b0, fifoFull = 1'b0, driveReq = 1'b0, driveIntr = 1'b0;
  logic [15:0] driveData = 16'h0;
  logic driveAck, pioGrant, fifoWrEn, engineIdle, ultraActive;
  logic [15:0] fifoWrData;

  int total = 0, bad = 0;
  int cyc = 0, wrCount = 0, prevWrCyc = 0, lastGap = 0;
  logic [15:0] expData = 16'h0;

  always #10 clk = ~clk;

  ata_rx_dma_engine #(.GAP_W(GAP_W)) uut (
    .clk(clk), .rstN(rstN), .dmaPending(dmaPending), .dirToDevice(dirToDevice),
    .ultraSel(ultraSel), .strobeGap(strobeGap), .pioReq(pioReq), .fifoFull(fifoFull),
    .driveReq(driveReq), .driveIntr(driveIntr), .driveData(driveData),
    .driveAck(driveAck), .pioGrant(pioGrant), .fifoWrEn(fifoWrEn),
    .fifoWrData(fifoWrData), .engineIdle(engineIdle), .ultraActive(ultraActive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wordPeriod(input bit ultra, input int gap);
    return ultra ? gap + 1 : 2 * (gap + 1);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // write monitor: samples mid-cycle, then advances the drive data sequence
  always @(negedge clk) begin
    if (rstN && fifoWrEn) begin
      check(fifoWrData == expData, "R4", fifoWrData, expData);
      check(!fifoFull, "R5", fifoFull, 0);
      check(driveReq, "R6", driveReq, 1);
      check(dmaPending, "R7", dmaPending, 1);
      lastGap   = cyc - prevWrCyc;
      prevWrCyc = cyc;
      wrCount++;
      expData   = expData + 16'd1;
      driveData = driveData + 16'd1;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  initial begin
    int snap;
    bit seen;
    void'($urandom(32'd1234));
    step(4);
    rstN = 1'b1;
    step(1);
    // R11 reset state
    check(engineIdle && !driveAck && !fifoWrEn && pioGrant, "R11", {engineIdle, driveAck, fifoWrEn, pioGrant}, 4'b1001);

    // R2 wrong direction
    dmaPending = 1; dirToDevice = 1; driveReq = 1;
    step(10);
    check(engineIdle && !driveAck && wrCount == 0, "R2", wrCount, 0);

    // R1 start in ultra mode
    dirToDevice = 0; ultraSel = 1; strobeGap = 4'd2;
    seen = 0;
    for (int i = 0; i < 4 && !seen; i++) begin step(1); seen = driveAck; end
    check(seen && !engineIdle, "R1", seen, 1);
    check(ultraActive == 1'b1, "R3", ultraActive, 1);
    step(30);
    check(lastGap == wordPeriod(1, 2), "R3", lastGap, wordPeriod(1, 2));

    // R5 fifo full stall
    fifoFull = 1; snap = wrCount;
    step(20);
    check(wrCount == snap, "R5", wrCount - snap, 0);
    check(driveAck == 1'b1, "R5", driveAck, 1);
    fifoFull = 0; step(10);
    check(wrCount > snap, "R8", wrCount - snap, 1);

    // R6 request drop
    driveReq = 0; snap = wrCount;
    step(20);
    check(wrCount == snap, "R6", wrCount - snap, 0);
    driveReq = 1; step(10);
    check(wrCount > snap, "R8", wrCount - snap, 1);

    // R7 pending cleared mid-transfer
    dmaPending = 0; snap = wrCount;
    step(20);
    check(wrCount == snap, "R7", wrCount - snap, 0);
    dmaPending = 1; step(10);
    check(wrCount > snap, "R8", wrCount - snap, 1);

    // R9 host register access
    pioReq = 1; snap = wrCount;
    step(3);
    check(pioGrant && !driveAck, "R9", {pioGrant, driveAck}, 2'b10);
    step(10);
    check(wrCount == snap, "R9", wrCount - snap, 0);
    pioReq = 0; step(12);
    check(driveAck && wrCount > snap, "R9", wrCount - snap, 1);

    // R10 end of transfer
    driveIntr = 1; step(1);
    check(engineIdle && !driveAck, "R10", {engineIdle, driveAck}, 2'b10);
    dmaPending = 0; driveIntr = 0; step(3);
    snap = wrCount;
    step(10);
    check(wrCount == snap && engineIdle, "R10", wrCount - snap, 0);

    // R3 multiword mode
    ultraSel = 0; strobeGap = 4'd3; dmaPending = 1;
    step(60);
    check(ultraActive == 1'b0, "R3", ultraActive, 0);
    check(lastGap == wordPeriod(0, 3), "R3", lastGap, wordPeriod(0, 3));

    // R4 R8 random stalls, data sequence checked by monitor
    snap = wrCount;
    for (int i = 0; i < 3000; i++) begin
      fifoFull = ($urandom % 10) < 3;
      driveReq = ($urandom % 10) != 0;
      pioReq   = ($urandom % 20) == 0;
      if ((i % 500) == 0) begin ultraSel = $urandom % 2; strobeGap = GAP_W'($urandom % 4); end
      step(1);
    end
    fifoFull = 0; driveReq = 1; pioReq = 0;
    step(40);
    check(wrCount > snap + 20, "R8", wrCount - snap, 21);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule